// File: doc/BRIEF.md
# I2C SCL Split-Phase Clock Generator

This block derives the SCL waveform of an I2C master from the peripheral clock. Each SCL period is built from a low phase followed by a high phase. The length of each phase is programmed as its own count, in units of eight peripheral clocks. Inside each phase the block raises a one-cycle strobe at the halfway point. The strobe in the low phase tells a bit engine that SDA may be driven to its next value. The strobe in the high phase tells it to sample SDA.

The two counts can be supplied directly. They can also be derived from one signed combined divisor, in which case a helper splits it into two halves and any odd remainder goes to the high phase. A bit engine can hold the generator with a stall input, which freezes its position in the current phase. Dropping the enable releases SCL high at once. Divider values are captured only when a new period begins.

Top module: `scl_phase_gen`

## Requirements
- R1: While `enable` is low, and from reset, `sclOut` is 1 and neither strobe is asserted.
- R2: After `enable` is sampled high by a clock edge, SCL goes low in the next cycle. Every period begins with its low phase.
- R3: With low count L, the low phase lasts 8*(L+1) cycles. With high count H, the high phase lasts 8*(H+1) cycles, so one period is 8*(L+H+2) cycles.
- R4: Number the low-phase cycles from 0. `sdaChangeStb` is high for exactly one cycle, at cycle 4*(L+1), while SCL is low.
- R5: Number the high-phase cycles from 0. `sdaSampleStb` is high for exactly one cycle, at cycle 4*(H+1), while SCL is high.
- R6: When `splitMode` is 1, the counts come from the two's-complement value D on `divIn`. For D >= 0, L = floor(D/2) and H = ceil(D/2), so the high count never trails the low count and exceeds it by at most one. `lowCntIn` and `highCntIn` are then ignored.
- R7: When `splitMode` is 1 and D is negative, both counts are 0, which gives a 16-cycle period.
- R8: Divider inputs are captured only at the first low cycle of a period. A change made partway through a period first shows in the following period.
- R9: Each clock edge that samples `hold` high while enabled leaves the phase position unchanged. SCL stays at its level, no strobe is raised during the hold, and the current phase is lengthened by one cycle for each such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator. Low releases SCL and clears the phase position |
| hold | input | 1 | Stalls the phase position while high |
| splitMode | input | 1 | 1 selects counts derived from `divIn`, 0 selects the direct counts |
| divIn | input | CNT_W+1 | Signed combined divisor |
| lowCntIn | input | CNT_W | Direct low-phase count |
| highCntIn | input | CNT_W | Direct high-phase count |
| sclOut | output | 1 | SCL level (1 = released) |
| sdaChangeStb | output | 1 | One-cycle strobe at the middle of the low phase |
| sdaSampleStb | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
Two functions can meet in one cycle: a hold sampled on the very clock edge that would advance the phase position toward its midpoint strobe, and a divider update arriving in the same period it is supposed to leave untouched. The bench raises `hold` a known number of cycles into a high phase. The following sample strobe must then arrive exactly as many cycles late as there were held edges, and SCL must stay high throughout. In a separate run the bench rewrites both counts in the middle of a low phase. It then checks every strobe-to-edge gap of that period against the old counts and every gap of the next period against the new ones.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Commands from the phase controller to the count datapath
  typedef struct packed {
    logic clearCnt;  // restart the phase position at zero
    logic stepCnt;   // advance the phase position by one cycle
    logic loadDiv;   // capture the divider inputs for a new period
  } sclCtrl_t;

endpackage

// File: rtl/scl_div_split.sv
module scl_div_split #(
  parameter int CNT_W = 8
) (
  input  logic signed [CNT_W:0]   divIn,
  output logic        [CNT_W-1:0] lowCnt,
  output logic        [CNT_W-1:0] highCnt
);

  localparam int SIGN_BIT = CNT_W;

  logic [CNT_W-1:0] halfDown;
  logic [CNT_W-1:0] oddUnit;

  // Floor half of the magnitude, and the odd unit that goes to the high phase
  assign halfDown = {1'b0, divIn[CNT_W-1:1]};
  assign oddUnit  = {{(CNT_W-1){1'b0}}, divIn[0]};

  always_comb begin
    if (divIn[SIGN_BIT]) begin
      lowCnt  = '0;
      highCnt = '0;
    end else begin
      lowCnt  = halfDown;
      highCnt = halfDown + oddUnit;
    end
  end

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     hold,
  input  logic     atEnd,
  input  logic     atMid,
  output logic     phaseHigh,
  output sclCtrl_t ctl,
  output logic     sclOut,
  output logic     sdaChangeStb,
  output logic     sdaSampleStb
);

  logic running;
  logic advancing;

  assign advancing = enable && running && !hold;

  always_comb begin
    ctl = '0;
    if (!enable) begin
      ctl.clearCnt = 1'b1;
    end else if (!running) begin
      ctl.clearCnt = 1'b1;
      ctl.loadDiv  = 1'b1;
    end else if (!hold) begin
      if (atEnd) begin
        ctl.clearCnt = 1'b1;
        ctl.loadDiv  = phaseHigh;
      end else begin
        ctl.stepCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (!enable) begin
      running   <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (!running) begin
      running   <= 1'b1;
      phaseHigh <= 1'b0;
    end else if (!hold && atEnd) begin
      phaseHigh <= !phaseHigh;
    end
  end

  assign sclOut       = !running || phaseHigh;
  assign sdaChangeStb = advancing && atMid && !phaseHigh;
  assign sdaSampleStb = advancing && atMid && phaseHigh;

endmodule

// File: rtl/scl_gen_dp.sv
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclCtrl_t         ctl,
  input  logic             phaseHigh,
  input  logic [CNT_W-1:0] lowIn,
  input  logic [CNT_W-1:0] highIn,
  output logic             atEnd,
  output logic             atMid
);

  localparam int POS_W = CNT_W + 3;  // eight clocks per count unit

  logic [CNT_W-1:0] curLow;
  logic [CNT_W-1:0] curHigh;
  logic [CNT_W-1:0] activeCnt;
  logic [POS_W-1:0] phasePos;
  logic [POS_W-1:0] endPos;
  logic [POS_W-1:0] midPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLow  <= '0;
      curHigh <= '0;
    end else if (ctl.loadDiv) begin
      curLow  <= lowIn;
      curHigh <= highIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phasePos <= '0;
    end else if (ctl.clearCnt) begin
      phasePos <= '0;
    end else if (ctl.stepCnt) begin
      phasePos <= phasePos + 1'b1;
    end
  end

  assign activeCnt = phaseHigh ? curHigh : curLow;
  assign endPos    = {activeCnt, 3'b111};
  assign midPos    = {({1'b0, activeCnt} + {{CNT_W{1'b0}}, 1'b1}), 2'b00};
  assign atEnd     = (phasePos == endPos);
  assign atMid     = (phasePos == midPos);

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               hold,
  input  logic               splitMode,
  input  logic signed [CNT_W:0] divIn,
  input  logic [CNT_W-1:0]   lowCntIn,
  input  logic [CNT_W-1:0]   highCntIn,
  output logic               sclOut,
  output logic               sdaChangeStb,
  output logic               sdaSampleStb
);

  sclCtrl_t         ctl;
  logic             phaseHigh;
  logic             atEnd;
  logic             atMid;
  logic [CNT_W-1:0] splitLow;
  logic [CNT_W-1:0] splitHigh;
  logic [CNT_W-1:0] selLow;
  logic [CNT_W-1:0] selHigh;

  scl_div_split #(.CNT_W(CNT_W)) u_split (
    .divIn   (divIn),
    .lowCnt  (splitLow),
    .highCnt (splitHigh)
  );

  assign selLow  = splitMode ? splitLow  : lowCntIn;
  assign selHigh = splitMode ? splitHigh : highCntIn;

  scl_gen_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .hold         (hold),
    .atEnd        (atEnd),
    .atMid        (atMid),
    .phaseHigh    (phaseHigh),
    .ctl          (ctl),
    .sclOut       (sclOut),
    .sdaChangeStb (sdaChangeStb),
    .sdaSampleStb (sdaSampleStb)
  );

  scl_gen_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .phaseHigh (phaseHigh),
    .lowIn     (selLow),
    .highIn    (selHigh),
    .atEnd     (atEnd),
    .atMid     (atMid)
  );

endmodule

// File: rtl/scl_phase_gen_checker.sv
module scl_phase_gen_checker #(
  parameter int CNT_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  enable,
  input logic                  hold,
  input logic signed [CNT_W:0] divIn,
  input logic [CNT_W-1:0]      splitLow,
  input logic [CNT_W-1:0]      splitHigh,
  input logic                  sclOut,
  input logic                  sdaChangeStb,
  input logic                  sdaSampleStb
);

  logic [CNT_W:0] splitDiff;
  assign splitDiff = {1'b0, splitHigh} - {1'b0, splitLow};

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !sdaChangeStb && !sdaSampleStb)); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> !sclOut); // R2

  AST_CHANGE_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sdaChangeStb |-> !sclOut); // R4

  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sdaSampleStb |-> sclOut); // R5

  AST_SPLIT_BALANCE: assert property (@(posedge clk) disable iff (!rstN)
    (splitHigh >= splitLow) && (splitDiff <= 1)); // R6

  AST_SPLIT_NEGATIVE: assert property (@(posedge clk) disable iff (!rstN)
    divIn[CNT_W] |-> (splitLow == '0 && splitHigh == '0)); // R7

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && hold) |=> $stable(sclOut)); // R9

endmodule

bind scl_phase_gen scl_phase_gen_checker #(.CNT_W(CNT_W)) u_check (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .hold         (hold),
  .divIn        (divIn),
  .splitLow     (splitLow),
  .splitHigh    (splitHigh),
  .sclOut       (sclOut),
  .sdaChangeStb (sdaChangeStb),
  .sdaSampleStb (sdaSampleStb)
);

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;

  localparam int CNT_W = 8;
  // event kinds seen on the outputs
  localparam int EV_FALL = 0;
  localparam int EV_CHG  = 1;
  localparam int EV_RISE = 2;
  localparam int EV_SMP  = 3;

  typedef struct {
    int    kind;
    int    gap;   // cycles since previous event, -1 = not checked
    string req;
  } expItem_t;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  enable = 1'b0;
  logic                  hold = 1'b0;
  logic                  splitMode = 1'b0;
  logic signed [CNT_W:0] divIn = '0;
  logic [CNT_W-1:0]      lowCntIn = '0;
  logic [CNT_W-1:0]      highCntIn = '0;
  logic                  sclOut;
  logic                  sdaChangeStb;
  logic                  sdaSampleStb;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFail = 0;
  int  cyc = 0;
  int  lastCyc = 0;
  logic prevScl = 1'b1;
  bit  finished = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  scl_phase_gen #(.CNT_W(CNT_W)) u_scl_phase_gen (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .hold         (hold),
    .splitMode    (splitMode),
    .divIn        (divIn),
    .lowCntIn     (lowCntIn),
    .highCntIn    (highCntIn),
    .sclOut       (sclOut),
    .sdaChangeStb (sdaChangeStb),
    .sdaSampleStb (sdaSampleStb)
  );

  task automatic pushExp(int kind, int gap, string req);
    expItem_t it;
    it.kind = kind;
    it.gap  = gap;
    it.req  = req;
    expQ.push_back(it);
  endtask

  task automatic seeEvent(int kind);
    int gap;
    expItem_t it;
    gap = cyc - lastCyc;
    lastCyc = cyc;
    nChecks++;
    if (expQ.size() == 0) begin
      nFail++;
      $display("FAIL R1 unexpected event: actual kind %0d gap %0d, expected none", kind, gap);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || (it.gap >= 0 && it.gap != gap)) begin
        nFail++;
        $display("FAIL %s: actual kind %0d gap %0d, expected kind %0d gap %0d",
                 it.req, kind, gap, it.kind, it.gap);
      end
    end
  endtask

  // Monitor: samples outputs after the drivers have settled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && !finished) begin
        if (prevScl && !sclOut) seeEvent(EV_FALL);
        if (sdaChangeStb)       seeEvent(EV_CHG);
        if (!prevScl && sclOut) seeEvent(EV_RISE);
        if (sdaSampleStb)       seeEvent(EV_SMP);
        prevScl = sclOut;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic checkDrained(string req);
    check(expQ.size() == 0, req, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic pushPeriod(int l, int h, bit last, string req);
    pushExp(EV_CHG,  4 * (l + 1), req);
    pushExp(EV_RISE, 4 * (l + 1), req);
    pushExp(EV_SMP,  4 * (h + 1), req);
    if (!last) pushExp(EV_FALL, 4 * (h + 1), req);
  endtask

  // Enable, expect P periods with counts l/h, then disable at the last high cycle
  task automatic runCase(int l, int h, int p, string req);
    @(negedge clk);
    enable = 1'b1;
    pushExp(EV_FALL, -1, req);
    for (int k = 0; k < p; k++) pushPeriod(l, h, k == p - 1, req);
    repeat (p * 8 * (l + h + 2)) @(negedge clk);
    enable = 1'b0;
    repeat (6) @(negedge clk);
    checkDrained(req);
  endtask

  task automatic runSplit(int d, int p, string req);
    int el;
    int eh;
    el = (d < 0) ? 0 : d / 2;
    eh = (d < 0) ? 0 : (d + 1) / 2;
    splitMode = 1'b1;
    divIn     = (CNT_W+1)'(d);
    lowCntIn  = 8'd9;   // must be ignored in split mode (R6)
    highCntIn = 8'd11;
    runCase(el, eh, p, req);
    splitMode = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(sclOut == 1'b1, "R1 reset scl", sclOut, 1);
    check(sdaChangeStb == 1'b0 && sdaSampleStb == 1'b0, "R1 reset strobes",
          sdaChangeStb + sdaSampleStb, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    lastCyc = cyc;

    // R2 R3 R4 R5: direct counts, several shapes
    lowCntIn = 8'd0; highCntIn = 8'd0;
    runCase(0, 0, 2, "R3 direct 0/0");
    lowCntIn = 8'd3; highCntIn = 8'd1;
    runCase(3, 1, 2, "R4 direct 3/1");
    lowCntIn = 8'd2; highCntIn = 8'd5;
    runCase(2, 5, 1, "R5 direct 2/5");

    // R6: combined divisor split, odd unit goes high
    runSplit(5, 2, "R6 split 5");
    runSplit(4, 1, "R6 split 4");
    runSplit(1, 1, "R6 split 1");
    // R7: negative divisor forces fastest clock
    runSplit(-3, 2, "R7 split -3");
    runSplit(-256, 1, "R7 split min");

    // R9: hold for 10 edges at high-phase cycle 2 of period 1 (counts 1/1)
    lowCntIn = 8'd1; highCntIn = 8'd1;
    @(negedge clk);
    enable = 1'b1;
    pushExp(EV_FALL, -1, "R9 hold");
    pushExp(EV_CHG, 8, "R9 hold");
    pushExp(EV_RISE, 8, "R9 hold");
    pushExp(EV_SMP, 18, "R9 hold");
    pushExp(EV_FALL, 8, "R9 hold");
    pushPeriod(1, 1, 1'b1, "R9 hold");
    repeat (19) @(negedge clk);
    hold = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(sclOut == 1'b1, "R9 scl frozen", sclOut, 1);
    end
    hold = 1'b0;
    repeat (45) @(negedge clk);
    enable = 1'b0;
    repeat (6) @(negedge clk);
    checkDrained("R9 hold");

    // R8: divider change in the middle of a low phase
    lowCntIn = 8'd1; highCntIn = 8'd1;
    @(negedge clk);
    enable = 1'b1;
    pushExp(EV_FALL, -1, "R8 update");
    pushPeriod(1, 1, 1'b0, "R8 update");
    pushPeriod(3, 2, 1'b1, "R8 update");
    repeat (5) @(negedge clk);
    lowCntIn = 8'd3; highCntIn = 8'd2;
    repeat (83) @(negedge clk);
    enable = 1'b0;
    repeat (6) @(negedge clk);
    checkDrained("R8 update");

    // R1: idle stays released with no strobes
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(sclOut == 1'b1, "R1 idle scl", sclOut, 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule